// File: doc/BRIEF.md
# Linear Burst Read Engine

This block sequences the read side of a synchronous burst memory. A low level on the address-valid strobe, while the chip is enabled, captures a start address. In synchronous burst mode the engine then presents one access per clock, walking linearly up from that address through a fixed burst of four 16-bit word slots. An end-of-burst indicator marks the access that carries the last word. The data bus is 32 bits wide. In narrow mode each access returns one 16-bit word. In wide mode each access returns two adjacent words, so a burst takes half as many accesses.

The outputs are modelled as separate value and drive-enable signals. The data bus and the indicator are driven only while a read is active, output enable is low and chip enable is low. Output enable only hides the outputs: the sequence keeps running behind it. A chip-enable rise or a fresh address strobe stops a burst. Reset also stops a burst and returns the configuration to its default, which is asynchronous single-access mode at 16-bit width. The memory array is stood in for by a computed pattern: the word at address `a` is `a XOR 16'h5A3C`.

Top module: `lbr_burst_top`

## Requirements
- R1: A clock edge with `rst_n` low ends any access and releases `dq_oe` and `ind_oe` (both 0). It also resets the configuration to asynchronous mode (`cfg_sync` 0) with the 16-bit bus (`cfg_wide` 0).
- R2: A clock edge with `ce_n` low and `adv_n` low captures `addr`. The first access appears right after that edge. In narrow mode `dq_o` is `{16'h0000, addr ^ 16'h5A3C}`.
- R3: In synchronous mode, each following edge with `adv_n` high advances the address by one word in narrow mode or by two words in wide mode. A wide access at address `a` reads `{word(a+1), word(a)}`.
- R4: With synchronous mode and the 16-bit bus, a burst has four accesses. `ind_o` is low on the fourth access only and high on the first three.
- R5: With synchronous mode and the 32-bit bus, a burst has two accesses. `ind_o` is low on the second access only.
- R6: On the edge after the last access the engine goes idle. `dq_oe` and `ind_oe` stay 0 until the next address strobe.
- R7: While `oe_n` is high, `dq_oe` and `ind_oe` are 0. While `oe_n` is low and an access is active, both are 1.
- R8: Holding `oe_n` high during a burst does not pause it. When `oe_n` returns low, the word shown is the one for the current position in the burst.
- R9: An edge with `ce_n` high ends the burst, and it does not resume when `ce_n` returns low. While `ce_n` is high, `dq_oe` and `ind_oe` are 0.
- R10: An address strobe during a burst discards it and restarts at the new address. While `adv_n` stays low, every edge reloads the address. Counting begins on the first edge with `adv_n` high.
- R11: In asynchronous mode a strobe gives one access, which is held unchanged with `ind_o` high until the next strobe, a chip-enable rise or a reset.
- R12: An edge with `cfg_we` high loads `cfg_sync` (1 selects synchronous burst) and `cfg_wide` (1 selects the 32-bit bus).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr | input | 16 | Start address, in 16-bit words |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_sync | input | 1 | 1 selects synchronous burst mode |
| cfg_wide | input | 1 | 1 selects the 32-bit data bus |
| dq_o | output | 32 | Data bus value |
| dq_oe | output | 1 | Data bus drive enable (0 means floating) |
| ind_o | output | 1 | End-of-burst indicator, low on the last access |
| ind_oe | output | 1 | Indicator drive enable (0 means floating) |

## Verification
The assertions check the following on every cycle:
- The outputs float whenever output enable or chip enable is high, and after any reset edge.
- The engine falls idle right after a visible end-of-burst access.
- The narrow-mode address steps by exactly one between accesses.
- An asynchronous access holds still.

The bench scenarios cover what needs a known start address and a known history:
- The exact word at each access.
- Where the indicator falls for each bus width.
- That a burst hidden by output enable has moved on when the outputs return.
- Restarts with the strobe held low.
- That a chip-enable abort does not resume.
- That reset restores asynchronous mode.

// File: rtl/lbr_pkg.sv
// Package for the linear burst read engine.
// Holds the configuration record shared by the register, the sequencer and the checker.
package lbr_pkg;

    // Operating configuration. The reset default is all zeros: asynchronous mode, 16-bit bus.
    typedef struct packed {
        logic sync;   // 1: synchronous linear burst
        logic wide;   // 1: 32-bit bus, two words per access
    } lbr_cfg_t;

    localparam lbr_cfg_t LBR_CFG_DEFAULT = '{sync: 1'b0, wide: 1'b0};

endpackage

// File: rtl/lbr_cfg_reg.sv
// Configuration register.
// Holds the access mode and the bus width. A synchronous reset returns it to the
// asynchronous 16-bit default. Assumes software changes it only while no burst runs.
module lbr_cfg_reg
    import lbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  lbr_cfg_t wdata,
    output lbr_cfg_t cfg
);

    lbr_cfg_t cfg_q;

    // Load on a write strobe; restore the default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= LBR_CFG_DEFAULT;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/lbr_seq.sv
// Burst sequencer.
// Captures the start address on the address strobe and counts accesses through a
// linear burst of BURST_WORDS word slots. Each access uses one slot on the narrow
// bus and two on the wide bus. In asynchronous mode it holds a single access.
// Assumes BURST_WORDS is even and at least 2.
module lbr_seq
    import lbr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BURST_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    input  lbr_cfg_t          cfg,
    output logic              busy,
    output logic              last,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int IDX_W     = $clog2(BURST_WORDS) + 1;
    localparam int ACC_NARROW = BURST_WORDS;
    localparam int ACC_WIDE   = BURST_WORDS / 2;

    logic              busy_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  last_idx;
    logic [ADDR_W-1:0] step;

    // Index of the final access and the address stride for the configured width.
    always_comb begin
        if (cfg.wide) begin
            last_idx = IDX_W'(ACC_WIDE - 1);
            step     = ADDR_W'(2);
        end else begin
            last_idx = IDX_W'(ACC_NARROW - 1);
            step     = ADDR_W'(1);
        end
    end

    // Capture, advance, abort and finish the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            addr_q <= '0;
        end else if (ce_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (!adv_n) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            addr_q <= addr;
        end else if (busy_q && cfg.sync) begin
            if (idx_q == last_idx) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + 1'b1;
                addr_q <= addr_q + step;
            end
        end
    end

    assign busy     = busy_q;
    assign last     = busy_q && cfg.sync && (idx_q == last_idx);
    assign cur_addr = addr_q;

endmodule

// File: rtl/lbr_out.sv
// Output stage.
// Forms the data word from the current address using the stand-in pattern.
// Drives the end-of-burst indicator and gates the drive enables of the data bus
// and the indicator. The enables react to the output-enable and chip-enable pins
// without waiting for a clock.
module lbr_out #(
    parameter int               ADDR_W  = 16,
    parameter int               WORD_W  = 16,
    parameter logic [WORD_W-1:0] PAT_KEY = 16'h5A3C
) (
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                wide,
    input  logic                busy,
    input  logic                last,
    input  logic [ADDR_W-1:0]   cur_addr,
    output logic [2*WORD_W-1:0] dq_o,
    output logic                dq_oe,
    output logic                ind_o,
    output logic                ind_oe
);

    logic [ADDR_W-1:0] next_addr;
    logic [WORD_W-1:0] word_lo;
    logic [WORD_W-1:0] word_hi;
    logic              drive;

    // Pattern words for the current address and the one above it.
    always_comb begin
        next_addr = cur_addr + 1'b1;
        word_lo   = WORD_W'(cur_addr) ^ PAT_KEY;
        word_hi   = WORD_W'(next_addr) ^ PAT_KEY;
    end

    // Place one word (narrow) or two words (wide) on the bus.
    always_comb begin
        if (wide) begin
            dq_o = {word_hi, word_lo};
        end else begin
            dq_o = {{WORD_W{1'b0}}, word_lo};
        end
    end

    // Drive only while an access is active and both enables are low.
    always_comb begin
        drive  = busy && !oe_n && !ce_n;
        dq_oe  = drive;
        ind_oe = drive;
        ind_o  = !last;
    end

endmodule

// File: rtl/lbr_burst_top.sv
// Top level of the linear burst read engine.
// Joins the configuration register, the burst sequencer and the output stage.
// All state is clocked on the rising edge with a synchronous active-low reset.
module lbr_burst_top
    import lbr_pkg::*;
#(
    parameter int               ADDR_W      = 16,
    parameter int               WORD_W      = 16,
    parameter int               BURST_WORDS = 4,
    parameter logic [WORD_W-1:0] PAT_KEY     = 16'h5A3C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                adv_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                cfg_we,
    input  logic                cfg_sync,
    input  logic                cfg_wide,
    output logic [2*WORD_W-1:0] dq_o,
    output logic                dq_oe,
    output logic                ind_o,
    output logic                ind_oe
);

    lbr_cfg_t          cfg;
    lbr_cfg_t          cfg_wdata;
    logic              seq_busy;
    logic              seq_last;
    logic [ADDR_W-1:0] seq_addr;

    // Gather the configuration write fields into the shared record.
    always_comb begin
        cfg_wdata.sync = cfg_sync;
        cfg_wdata.wide = cfg_wide;
    end

    lbr_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    lbr_seq #(
        .ADDR_W      (ADDR_W),
        .BURST_WORDS (BURST_WORDS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .adv_n    (adv_n),
        .addr     (addr),
        .cfg      (cfg),
        .busy     (seq_busy),
        .last     (seq_last),
        .cur_addr (seq_addr)
    );

    lbr_out #(
        .ADDR_W  (ADDR_W),
        .WORD_W  (WORD_W),
        .PAT_KEY (PAT_KEY)
    ) u_out (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .wide     (cfg.wide),
        .busy     (seq_busy),
        .last     (seq_last),
        .cur_addr (seq_addr),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe),
        .ind_o    (ind_o),
        .ind_oe   (ind_oe)
    );

endmodule

// File: rtl/lbr_burst_chk.sv
// Assertion checker for the linear burst read engine, bound into the top level.
// It watches the ports together with the sequencer and configuration state.
module lbr_burst_chk #(
    parameter int               WORD_W  = 16,
    parameter logic [WORD_W-1:0] PAT_KEY = 16'h5A3C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              adv_n,
    input logic              cfg_we,
    input logic              sync,
    input logic              wide,
    input logic              busy,
    input logic [WORD_W-1:0] dq_lo,
    input logic              dq_oe,
    input logic              ind_o,
    input logic              ind_oe
);

    // R1
    reset_floats_chk: assert property (@(posedge clk)
        !rst_n |=> (!dq_oe && !ind_oe));

    // R7
    oe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dq_oe && !ind_oe));

    // R9
    ce_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!dq_oe && !ind_oe));

    // R6
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_oe && !ind_o && adv_n) |=> !dq_oe);

    // R3
    narrow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sync && !wide && ind_o && adv_n && !ce_n && !cfg_we)
        |=> ((dq_lo ^ PAT_KEY) == WORD_W'($past(dq_lo ^ PAT_KEY) + 1'b1)));

    // R11
    async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sync && adv_n && !ce_n && !cfg_we) |=> ($stable(dq_lo) && ind_o));

endmodule

bind lbr_burst_top lbr_burst_chk #(
    .WORD_W  (WORD_W),
    .PAT_KEY (PAT_KEY)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .adv_n  (adv_n),
    .cfg_we (cfg_we),
    .sync   (cfg.sync),
    .wide   (cfg.wide),
    .busy   (seq_busy),
    .dq_lo  (dq_o[WORD_W-1:0]),
    .dq_oe  (dq_oe),
    .ind_o  (ind_o),
    .ind_oe (ind_oe)
);

// File: tb/lbr_burst_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs for each cycle it drives.
// The monitor pops and compares them just after the following rising edge.
module lbr_burst_top_tb;

    typedef struct {
        logic        oe;
        logic        ind;
        logic [31:0] dq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        adv_n = 1'b1;
    logic [15:0] addr = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_sync = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [31:0] dq_o;
    logic        dq_oe;
    logic        ind_o;
    logic        ind_oe;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    lbr_burst_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .adv_n    (adv_n),
        .addr     (addr),
        .cfg_we   (cfg_we),
        .cfg_sync (cfg_sync),
        .cfg_wide (cfg_wide),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe),
        .ind_o    (ind_o),
        .ind_oe   (ind_oe)
    );

    function automatic logic [15:0] w(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    function automatic logic [31:0] n16(input logic [15:0] a);
        return {16'h0000, w(a)};
    endfunction

    function automatic logic [31:0] n32(input logic [15:0] a);
        return {w(a + 16'd1), w(a)};
    endfunction

    // Drive one cycle of inputs and queue the outputs expected after the next edge.
    task automatic cyc(input logic r, input logic ce, input logic oe, input logic adv,
                       input logic [15:0] a, input logic we, input logic s, input logic wd,
                       input logic e_oe, input logic e_ind, input logic [31:0] e_dq,
                       input string tag);
        exp_t it;
        @(negedge clk);
        rst_n = r; ce_n = ce; oe_n = oe; adv_n = adv; addr = a;
        cfg_we = we; cfg_sync = s; cfg_wide = wd;
        it.oe = e_oe; it.ind = e_ind; it.dq = e_dq; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare the outputs against the queue just after each rising edge.
    always @(posedge clk) begin
        exp_t it;
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (dq_oe !== it.oe || ind_oe !== it.oe) begin
                failures++;
                $display("FAIL %s enables dq_oe=%b ind_oe=%b expected %b",
                         it.tag, dq_oe, ind_oe, it.oe);
            end
            if (it.oe) begin
                checks++;
                if (ind_o !== it.ind) begin
                    failures++;
                    $display("FAIL %s ind_o=%b expected %b", it.tag, ind_o, it.ind);
                end
                checks++;
                if (dq_o !== it.dq) begin
                    failures++;
                    $display("FAIL %s dq_o=%h expected %h", it.tag, dq_o, it.dq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus scenarios.
    initial begin
        // R1 reset state: outputs floating
        cyc(0,1,1,1,16'h0000,0,0,0, 0,1,0, "R1 reset");
        cyc(0,0,0,1,16'h0000,0,0,0, 0,1,0, "R1 reset held");
        // R11 default async mode: one access held
        cyc(1,0,0,0,16'h0010,0,0,0, 1,1,n16(16'h0010), "R11 R2 async capture");
        cyc(1,0,0,1,16'h0000,0,0,0, 1,1,n16(16'h0010), "R11 async hold");
        cyc(1,0,0,1,16'h0000,0,0,0, 1,1,n16(16'h0010), "R11 async hold 2");
        // R12 load sync/narrow with ce_n high; R9 float
        cyc(1,1,0,1,16'h0000,1,1,0, 0,1,0, "R12 R9 cfg write ce high");
        // R4 narrow burst of four
        cyc(1,0,0,0,16'h0100,0,0,0, 1,1,n16(16'h0100), "R2 R4 access1");
        cyc(1,0,0,1,16'h0000,0,0,0, 1,1,n16(16'h0101), "R3 R4 access2");
        cyc(1,0,0,1,16'h0000,0,0,0, 1,1,n16(16'h0102), "R3 R4 access3");
        cyc(1,0,0,1,16'h0000,0,0,0, 1,0,n16(16'h0103), "R4 access4 last");
        cyc(1,0,0,1,16'h0000,0,0,0, 0,1,0, "R6 idle");
        // R12 load wide; R5 two accesses
        cyc(1,0,0,1,16'h0000,1,1,1, 0,1,0, "R12 R6 cfg wide idle");
        cyc(1,0,0,0,16'h0200,0,1,1, 1,1,n32(16'h0200), "R5 R3 wide access1");
        cyc(1,0,0,1,16'h0000,0,1,1, 1,0,n32(16'h0202), "R5 R3 wide access2 last");
        cyc(1,0,0,1,16'h0000,0,1,1, 0,1,0, "R6 idle after wide");
        // R7 R8 output enable floats but burst continues
        cyc(1,0,0,1,16'h0000,1,1,0, 0,1,0, "R12 back to narrow");
        cyc(1,0,0,0,16'h0300,0,1,0, 1,1,n16(16'h0300), "R8 access1");
        cyc(1,0,1,1,16'h0000,0,1,0, 0,1,0, "R7 oe high float");
        cyc(1,0,1,1,16'h0000,0,1,0, 0,1,0, "R7 oe high float 2");
        cyc(1,0,0,1,16'h0000,0,1,0, 1,0,n16(16'h0303), "R8 burst advanced");
        cyc(1,0,0,1,16'h0000,0,1,0, 0,1,0, "R6 idle after oe");
        // R10 restart mid-burst, strobe held low
        cyc(1,0,0,0,16'h0400,0,1,0, 1,1,n16(16'h0400), "R10 first burst");
        cyc(1,0,0,1,16'h0000,0,1,0, 1,1,n16(16'h0401), "R10 first burst 2");
        cyc(1,0,0,0,16'h0500,0,1,0, 1,1,n16(16'h0500), "R10 restart");
        cyc(1,0,0,0,16'h0500,0,1,0, 1,1,n16(16'h0500), "R10 strobe held");
        cyc(1,0,0,1,16'h0000,0,1,0, 1,1,n16(16'h0501), "R10 count 2");
        cyc(1,0,0,1,16'h0000,0,1,0, 1,1,n16(16'h0502), "R10 count 3");
        cyc(1,0,0,1,16'h0000,0,1,0, 1,0,n16(16'h0503), "R10 R4 last");
        cyc(1,0,0,1,16'h0000,0,1,0, 0,1,0, "R6 idle after restart");
        // R9 chip-enable abort, no resume
        cyc(1,0,0,0,16'h0600,0,1,0, 1,1,n16(16'h0600), "R9 burst start");
        cyc(1,1,0,1,16'h0000,0,1,0, 0,1,0, "R9 ce high abort");
        cyc(1,0,0,1,16'h0000,0,1,0, 0,1,0, "R9 no resume");
        // R1 reset mid-burst returns to async default
        cyc(1,0,0,0,16'h0700,0,1,0, 1,1,n16(16'h0700), "R1 burst before reset");
        cyc(0,0,0,1,16'h0000,0,1,0, 0,1,0, "R1 reset mid-burst");
        cyc(1,0,0,0,16'h0800,0,1,0, 1,1,n16(16'h0800), "R1 async after reset");
        cyc(1,0,0,1,16'h0000,0,1,0, 1,1,n16(16'h0800), "R1 R11 held after reset");
        cyc(1,0,0,1,16'h0000,0,1,0, 1,1,n16(16'h0800), "R1 R11 held after reset 2");
        // drain the scoreboard
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule